// File: doc/BRIEF.md
# ADC Mode Control Sequencer

This block holds the 8-bit mode register of a sigma-delta converter front end and runs the control sequence it selects. The register is written over a simple memory-mapped write port and read back at all times. A 3-bit mode field picks power-down, idle, one-shot conversion, free-running conversion, or one of four calibrations. Two enable bits power the primary and auxiliary converters. One bit requests an extra 60 Hz notch. One bit turns off chopping.

From the register and the current filter word, the block drives several outputs: the converter power controls, the filter/modulator reset, the input routing select and a conversion-start strobe. A converter outside the block answers each start with a one-cycle completion pulse. The block turns that pulse into a data-register load, a ready-flag set or a calibration-done set. After a one-shot conversion or any calibration it rewrites its own mode field to power-down. It also applies the filter-word limits that the notch and chop options depend on.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the register reads 0x08: mode field (bits 2:0) 000, chop-disable (bit 3) set, all other bits clear. `mod_rst` is high and `conv_start` is low.
- R2: Bit 7 always reads 0, whatever was written to it. A write whose `wr_addr` differs from 0xD1 leaves the register unchanged.
- R3: `conv_on[0]` is high only when bit 5 is set and the mode field is not 000. `conv_on[1]` follows the same rule with bit 4. With both enables clear or the mode at 000, `mod_rst` is high and no start is issued.
- R4: In idle mode (001), the enabled converters stay powered but `mod_rst` is held high and no conversion starts.
- R5: When a write selects one-shot mode (010), `conv_start` pulses in the cycle after the write. A `conv_done` pulse then raises `data_load` and `rdy_set` for one cycle and sets the mode field to 000. No further start follows.
- R6: In free-running mode (011), every `conv_done` raises `data_load` and `rdy_set`. The mode field stays 011, and a new `conv_start` follows one cycle after the load.
- R7: In the calibration modes (1xx), `conv_done` raises `cal_set` without `data_load`, and the mode field returns to 000.
- R8: `route_sel` is 01 (shorted input) for mode 100 and 10 (reference) for mode 101. It is 00 (selected channel) for every other mode.
- R9: `notch_on` is high only when bit 6 is set and `filt_word` is at least 68.
- R10: `filt_ok` requires `filt_word` >= 13 with chop on (bit 3 clear) and >= 3 with chop off. No `conv_start` is issued while `filt_ok` is low.
- R11: A register write while a conversion is pending aborts it. `mod_rst` pulses in the cycle after the write, and the newly written mode starts one cycle later.
- R12: A `conv_done` pulse while no conversion is pending is ignored. No load, ready or calibration strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address, decoded against 0xD1 |
| wr_data | input | 8 | Write data |
| filt_word | input | 8 | Current filter word from the filter setup |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| rd_data | output | 8 | Register read-back |
| conv_on | output | 2 | Converter power: bit 0 primary, bit 1 auxiliary |
| mod_rst | output | 1 | Filter and modulator reset |
| route_sel | output | 2 | Input routing: 00 channel, 01 short, 10 reference |
| conv_start | output | 1 | Conversion start strobe |
| data_load | output | 1 | Data register load strobe |
| rdy_set | output | 1 | Ready flag set strobe |
| cal_set | output | 1 | Calibration-done flag set strobe |
| notch_on | output | 1 | Effective 60 Hz notch request |
| filt_ok | output | 1 | Filter word legal for the chop setting |

## Verification
The bench targets the self-clearing mode field after one-shot and calibration completions. A design that forgot to clear it would keep restarting conversions, and one that cleared it in free-running mode would stop after the first result. A write landing on a pending conversion is also tested: a design without the abort would miss the reset pulse or the restart of the new mode. The bench covers a completion pulse arriving in idle, which a careless design would turn into a spurious load. It also covers the filter-word limits at 3, 13, 67 and 82, where an off-by-one comparison would let a start through or drop the notch.

// File: rtl/adc_mode_pkg.sv
// Shared mode and routing encodings for the ADC mode sequencer.
// Assumes the 3-bit mode field layout of the mode register.
package adc_mode_pkg;

    typedef enum logic [2:0] {
        MD_OFF    = 3'b000,
        MD_IDLE   = 3'b001,
        MD_ONE    = 3'b010,
        MD_RUN    = 3'b011,
        MD_ZS_INT = 3'b100,
        MD_FS_INT = 3'b101,
        MD_ZS_SYS = 3'b110,
        MD_FS_SYS = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        RT_CHAN  = 2'b00,
        RT_SHORT = 2'b01,
        RT_REF   = 2'b10
    } route_e;

    // True for modes that launch a conversion or calibration.
    function automatic logic mode_runs(input logic [2:0] m);
        return m[2] | m[1];
    endfunction

    // True for the calibration modes.
    function automatic logic mode_cal(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/adc_mode_reg.sv
// Mode register: holds the 7 implemented bits and decodes writes at one address.
// Assumes the sequencer requests the mode-field clear only when no write hits.
module adc_mode_reg #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  REG_ADDR  = 8'hD1,
    parameter logic [6:0]  RESET_VAL = 7'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              clr_mode,
    output logic              wr_hit,
    output logic [6:0]        ctl
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    // Address decode of the write port.
    assign wr_hit = wr_en && (wr_addr == HIT_ADDR);

    // Register update: software write wins over the sequencer's self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= RESET_VAL;
        end else if (wr_hit) begin
            ctl <= wr_data[6:0];
        end else if (clr_mode) begin
            ctl[2:0] <= 3'b000;
        end
    end
endmodule

// File: rtl/adc_filt_rules.sv
// Filter-word rules: legality for the chop setting and gating of the notch.
// Assumes filt_word is an unsigned decimation word.
module adc_filt_rules #(
    parameter int FW_W      = 8,
    parameter int NOTCH_MIN = 68,
    parameter int CHOP_MIN  = 13,
    parameter int FAST_MIN  = 3
) (
    input  logic [FW_W-1:0] filt_word,
    input  logic            chop_off,
    input  logic            notch_req,
    output logic            filt_ok,
    output logic            notch_on
);
    localparam logic [FW_W-1:0] NOTCH_LIM = FW_W'(NOTCH_MIN);
    localparam logic [FW_W-1:0] CHOP_LIM  = FW_W'(CHOP_MIN);
    localparam logic [FW_W-1:0] FAST_LIM  = FW_W'(FAST_MIN);

    // Lower bound picked by the chop setting; notch only above its limit.
    always_comb begin
        filt_ok  = chop_off ? (filt_word >= FAST_LIM) : (filt_word >= CHOP_LIM);
        notch_on = notch_req && (filt_word >= NOTCH_LIM);
    end
endmodule

// File: rtl/adc_mode_fsm.sv
// Conversion sequencer: issues starts, waits for completion, raises result
// strobes, aborts on writes. Assumes conv_done is a one-cycle pulse.
module adc_mode_fsm
    import adc_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       any_en,
    input  logic       filt_ok,
    input  logic       wr_hit,
    input  logic       conv_done,
    output logic       clr_mode,
    output logic       conv_start,
    output logic       data_load,
    output logic       rdy_set,
    output logic       cal_set,
    output logic       abort_q
);
    typedef enum logic {ST_WAIT, ST_BUSY} st_e;
    st_e  st;
    logic run_ok;
    logic done_hit;

    // Launch condition and accepted completion.
    assign run_ok   = mode_runs(mode) && any_en && filt_ok;
    assign done_hit = (st == ST_BUSY) && conv_done && !wr_hit;
    // One-shot and calibration modes fall back to power-down on completion.
    assign clr_mode = done_hit && (mode != MD_RUN);

    // State and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_WAIT;
            conv_start <= 1'b0;
            data_load  <= 1'b0;
            rdy_set    <= 1'b0;
            cal_set    <= 1'b0;
            abort_q    <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            data_load  <= 1'b0;
            rdy_set    <= 1'b0;
            cal_set    <= 1'b0;
            abort_q    <= 1'b0;
            if (wr_hit) begin
                abort_q <= (st == ST_BUSY);
                st      <= ST_WAIT;
            end else if (st == ST_WAIT) begin
                if (run_ok) begin
                    conv_start <= 1'b1;
                    st         <= ST_BUSY;
                end
            end else if (done_hit) begin
                data_load <= !mode_cal(mode);
                rdy_set   <= !mode_cal(mode);
                cal_set   <= mode_cal(mode);
                st        <= ST_WAIT;
            end
        end
    end
endmodule

// File: rtl/adc_mode_seq.sv
// Top of the ADC mode sequencer: register, filter rules, sequencer, and the
// power, reset and routing decode. Assumes one primary and one auxiliary converter.
module adc_mode_seq
    import adc_mode_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          FW_W      = 8,
    parameter logic [7:0]  REG_ADDR  = 8'hD1,
    parameter int          NOTCH_MIN = 68,
    parameter int          CHOP_MIN  = 13,
    parameter int          FAST_MIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [FW_W-1:0]   filt_word,
    input  logic              conv_done,
    output logic [7:0]        rd_data,
    output logic [1:0]        conv_on,
    output logic              mod_rst,
    output logic [1:0]        route_sel,
    output logic              conv_start,
    output logic              data_load,
    output logic              rdy_set,
    output logic              cal_set,
    output logic              notch_on,
    output logic              filt_ok
);
    localparam int NUM_CONV = 2;
    localparam int EN_TOP   = 5;

    logic [6:0] ctl;
    logic       wr_hit;
    logic       clr_mode;
    logic       abort_q;
    logic [2:0] mode;
    logic       any_en;

    assign mode    = ctl[2:0];
    assign any_en  = ctl[5] | ctl[4];
    assign rd_data = {1'b0, ctl};

    adc_mode_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RESET_VAL(7'h08)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_mode(clr_mode), .wr_hit(wr_hit), .ctl(ctl)
    );

    adc_filt_rules #(.FW_W(FW_W), .NOTCH_MIN(NOTCH_MIN), .CHOP_MIN(CHOP_MIN),
                     .FAST_MIN(FAST_MIN)) u_rules (
        .filt_word(filt_word), .chop_off(ctl[3]), .notch_req(ctl[6]),
        .filt_ok(filt_ok), .notch_on(notch_on)
    );

    adc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .any_en(any_en),
        .filt_ok(filt_ok), .wr_hit(wr_hit), .conv_done(conv_done),
        .clr_mode(clr_mode), .conv_start(conv_start), .data_load(data_load),
        .rdy_set(rdy_set), .cal_set(cal_set), .abort_q(abort_q)
    );

    // Per-converter power: enable bit set and mode not power-down.
    for (genvar g = 0; g < NUM_CONV; g++) begin : g_pwr
        assign conv_on[g] = ctl[EN_TOP - g] && (mode != MD_OFF);
    end

    // Filter/modulator reset and input routing from the mode field.
    always_comb begin
        mod_rst = (mode == MD_OFF) || (mode == MD_IDLE) || !any_en || abort_q;
        case (mode)
            MD_ZS_INT: route_sel = RT_SHORT;
            MD_FS_INT: route_sel = RT_REF;
            default:   route_sel = RT_CHAN;
        endcase
    end
endmodule

// File: rtl/adc_mode_seq_chk.sv
// Port-level checker for the ADC mode sequencer, attached by bind.
module adc_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic [7:0] filt_word,
    input logic       conv_done,
    input logic [1:0] conv_on,
    input logic       mod_rst,
    input logic       conv_start,
    input logic       data_load,
    input logic       cal_set,
    input logic       notch_on,
    input logic       filt_ok
);
    a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0);
    a_r3_pri_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[5] |-> !conv_on[0]);
    a_r4_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2:0] == 3'b001) |-> mod_rst);
    a_r5_load_mode: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |-> (rd_data[2:0] == 3'b000 || rd_data[2:0] == 3'b011));
    a_r7_cal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cal_set |-> (rd_data[2:0] == 3'b000 && !data_load));
    a_r9_notch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        notch_on |-> (rd_data[6] && filt_word >= 8'd68));
    a_r10_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(filt_ok));
    a_r12_load_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        (data_load || cal_set) |-> $past(conv_done));
endmodule

bind adc_mode_seq adc_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .filt_word(filt_word),
    .conv_done(conv_done), .conv_on(conv_on), .mod_rst(mod_rst),
    .conv_start(conv_start), .data_load(data_load), .cal_set(cal_set),
    .notch_on(notch_on), .filt_ok(filt_ok)
);

// File: tb/adc_mode_seq_bench.sv
module adc_mode_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'hD1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] filt_word = 8'd20;
    logic       conv_done = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] conv_on;
    logic       mod_rst, conv_start, data_load, rdy_set, cal_set, notch_on, filt_ok;
    logic [1:0] route_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    adc_mode_seq u_adc_mode_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .filt_word(filt_word), .conv_done(conv_done),
        .rd_data(rd_data), .conv_on(conv_on), .mod_rst(mod_rst),
        .route_sel(route_sel), .conv_start(conv_start), .data_load(data_load),
        .rdy_set(rdy_set), .cal_set(cal_set), .notch_on(notch_on), .filt_ok(filt_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {data, fw, rd, route, mod_rst, pri, aux, notch, ok, 1'b0}
    localparam logic [31:0] VEC [13] = '{
        {8'h08, 8'd20, 8'h08, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h31, 8'd20, 8'h31, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h3B, 8'd3,  8'h3B, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h3B, 8'd2,  8'h3B, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h33, 8'd12, 8'h33, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h33, 8'd13, 8'h33, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h24, 8'd20, 8'h24, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h15, 8'd20, 8'h15, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h36, 8'd20, 8'h36, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h62, 8'd82, 8'h62, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h62, 8'd67, 8'h62, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h42, 8'd82, 8'h42, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'hB7, 8'd20, 8'h37, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
    endtask

    task automatic park();
        wr(RA, 8'h08);
        step();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "rd_data", rd_data, 8'h08);
        chk("R1", "mod_rst", mod_rst, 1);
        chk("R1", "conv_start", conv_start, 0);

        // Decode table: R2 R3 R8 R9 R10
        for (int i = 0; i < 13; i++) begin
            park();
            filt_word = VEC[i][23:16];
            wr(RA, VEC[i][31:24]);
            chk("R2", "rd_data", rd_data, VEC[i][15:8]);
            chk("R8", "route_sel", route_sel, VEC[i][7:6]);
            chk("R3", "mod_rst", mod_rst, VEC[i][5]);
            chk("R3", "conv_on", conv_on, {VEC[i][3], VEC[i][4]});
            chk("R9", "notch_on", notch_on, VEC[i][2]);
            chk("R10", "filt_ok", filt_ok, VEC[i][1]);
        end

        // R5 one-shot conversion
        park(); filt_word = 8'd20;
        wr(RA, 8'h22);
        chk("R5", "start early", conv_start, 0);
        step();
        chk("R5", "start", conv_start, 1);
        done_pulse();
        chk("R5", "data_load", data_load, 1);
        chk("R5", "rdy_set", rdy_set, 1);
        chk("R5", "mode cleared", rd_data, 8'h20);
        step();
        chk("R5", "no restart", conv_start, 0);
        chk("R5", "reset after", mod_rst, 1);

        // R6 free-running conversion
        park();
        wr(RA, 8'h23);
        step();
        chk("R6", "start", conv_start, 1);
        done_pulse();
        chk("R6", "data_load", data_load, 1);
        chk("R6", "mode kept", rd_data, 8'h23);
        step();
        chk("R6", "restart", conv_start, 1);
        done_pulse();
        chk("R6", "second load", rdy_set, 1);

        // R7 calibration
        park();
        wr(RA, 8'h24);
        step();
        chk("R7", "start", conv_start, 1);
        done_pulse();
        chk("R7", "cal_set", cal_set, 1);
        chk("R7", "no data_load", data_load, 0);
        chk("R7", "mode cleared", rd_data, 8'h20);

        // R11 abort on write
        park();
        wr(RA, 8'h23);
        step();
        chk("R11", "first start", conv_start, 1);
        wr(RA, 8'h24);
        chk("R11", "abort reset", mod_rst, 1);
        chk("R11", "no start yet", conv_start, 0);
        step();
        chk("R11", "new start", conv_start, 1);
        chk("R11", "reset released", mod_rst, 0);
        chk("R11", "route short", route_sel, 2'b01);

        // R10 illegal filter word blocks starts
        park(); filt_word = 8'd5;
        wr(RA, 8'h23);
        step();
        chk("R10", "blocked start", conv_start, 0);
        step();
        chk("R10", "still blocked", conv_start, 0);
        filt_word = 8'd20;
        step();
        chk("R10", "start once legal", conv_start, 1);

        // R3 both enables clear
        park();
        wr(RA, 8'h03);
        step();
        chk("R3", "no start disabled", conv_start, 0);
        chk("R3", "powered off", conv_on, 0);
        chk("R3", "reset disabled", mod_rst, 1);

        // R4 idle and R12 stray completion
        park();
        wr(RA, 8'h31);
        step();
        chk("R4", "no start idle", conv_start, 0);
        chk("R4", "powered idle", conv_on, 2'b11);
        done_pulse();
        chk("R12", "no load", data_load, 0);
        chk("R12", "no ready", rdy_set, 0);
        chk("R12", "no cal", cal_set, 0);
        chk("R12", "mode kept", rd_data, 8'h31);

        // R2 write to another address
        wr(8'hD0, 8'h23);
        chk("R2", "other address", rd_data, 8'h31);

        report();
    end
endmodule